// File: doc/BRIEF.md
# UART Host Register File with Interrupt Prioritiser

This block is the byte-wide host side of a FIFO-based UART. A processor selects it with a chip-select and issues single-cycle read or write strobes on a three-bit offset. The block turns these accesses into a push toward the transmit FIFO and a pop from the receive FIFO. It holds the framing configuration, the FIFO settings and the 16-bit baud divisor, and it drives those values to the serial engines, which sit outside this block.

Four interrupt sources are ranked. Only the highest-ranked pending source appears in a read-only status byte, and all enabled sources are combined into one interrupt line. Changes on the four modem inputs are synchronised and held as sticky flags until software reads them. A divisor-access bit in the line settings sends offsets 0 and 1 to the two divisor bytes. A small counter derived from the divisor gives a tick at sixteen times the bit rate.

Top module: `uart_regfile`

## Requirements
- R1: After reset, irq is 0, the divisor output equals 1, fifo_en, the clear pulses and the line outputs are 0, and the status byte reads 0x01 (no interrupt pending).
- R2: A write to offset 0 with the divisor-access bit (line byte bit 7) clear asserts tx_push for that strobe with tx_data equal to wdata. A read of offset 0 asserts rx_pop and returns rx_data. Accesses to other offsets raise neither.
- R3: While line byte bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes, the divisor output shows {high, low}, and tx_push and rx_pop stay low.
- R4: Offset 3 (line byte: bits 1:0 word length, bit 2 stop bits, bits 5:3 parity, bit 6 break, bit 7 divisor access) and offset 5 (scratch) read back what was written. Offset 1 keeps only bits 3:0 (bit 0 receive data, bit 1 transmit empty, bit 2 line error, bit 3 modem). Offsets 6 and 7 read 0. Accesses to scratch change nothing else.
- R5: Offset 2 is write-only for FIFO settings: bit 0 FIFO enable, bit 1 receive clear, bit 2 transmit clear, bits 7:6 receive trigger select. Each clear bit gives a pulse exactly one cycle long after the write. A read of offset 2 returns the status byte.
- R6: The receive-data request is active when rx_level is at or above the trigger: 1, DEPTH/4, DEPTH/2 or DEPTH-2 for select 0 to 3 (1, 4, 8 and 14 at depth 16). The trigger is 1 whenever the FIFO is disabled.
- R7: Status byte codes are 0x06 for a line error, 0x04 for receive data, 0x02 for transmit empty, 0x00 for a modem change and 0x01 for none. When several sources are pending, the one earlier in this list is shown.
- R8: The transmit-empty request is latched on a rising tx_empty, or when its enable bit is set while tx_empty is high. It is cleared by a status read that shows code 0x02, or by a transmit push.
- R9: Offset 4 returns the synchronised modem inputs in bits 7:4 and the sticky change flags in bits 3:0. A read clears the flags, but a change that lands in the same cycle as the read survives it.
- R10: With divisor D > 0, baud_tick is high for exactly one cycle in every D cycles. With D = 0 it never rises.
- R11: irq is high exactly when at least one source whose enable bit is set is pending. A disabled source neither raises irq nor appears in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid during the read strobe |
| irq | output | 1 | Combined interrupt request |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | DATA_W | Byte to push |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | DATA_W | Head byte of the receive FIFO |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_line_err | input | 1 | A receive error is pending |
| modem_in | input | MODEM_W | Modem status inputs |
| fifo_en | output | 1 | FIFO mode enable |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO clear |
| word_len | output | 2 | Word length select |
| stop_two | output | 1 | Extra stop bit select |
| parity_mode | output | 3 | Parity control |
| brk | output | 1 | Force break on the line |
| divisor | output | 2*DATA_W | Baud divisor |
| baud_tick | output | 1 | Tick at sixteen times the bit rate |

## Verification
Two collisions matter in this block. The first is a modem status read that falls in the same cycle as the edge where a synchronised input change sets its flag. The bench counts the synchroniser stages and places the read strobe on that exact edge. A second read then has to show the flag still set, which confirms that setting wins over clearing. The second collision is a status read racing the transmit-empty latch. The bench walks the full priority chain, removing one source at a time, so that each status read shows which source was seen and which one was cleared.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

   // register offsets
   localparam int OFS_DATA = 0;
   localparam int OFS_IEN  = 1;
   localparam int OFS_ISR  = 2;
   localparam int OFS_LCR  = 3;
   localparam int OFS_MSR  = 4;
   localparam int OFS_SCR  = 5;

   // enable bit positions
   localparam int IEN_RXD  = 0;
   localparam int IEN_TXE  = 1;
   localparam int IEN_LINE = 2;
   localparam int IEN_MDM  = 3;
   localparam int IEN_W    = 4;

   // source index: lower index means higher priority
   localparam int NSRC = 4;
   typedef enum logic [1:0] {
      SRC_LINE = 2'd0,
      SRC_RXD  = 2'd1,
      SRC_TXE  = 2'd2,
      SRC_MDM  = 2'd3
   } src_e;

   typedef struct packed {
      logic       dlab;
      logic       brk;
      logic [2:0] par;
      logic       stop2;
      logic [1:0] wlen;
   } line_cfg_t;

   function automatic logic [2:0] src_code(input int idx);
      return 3'(NSRC - 1 - idx);
   endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter int NREQ  = 4,
   parameter int IDX_W = $clog2(NREQ)
) (
   input  logic [NREQ-1:0]  req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = NREQ - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status #(
   parameter int W           = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic         clr,
   output logic [W-1:0] now,
   output logic [W-1:0] delta
);

   logic [W-1:0] prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign now = pins;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '0;
            end else begin
               stg[0] <= pins;
               for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign now = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '0;
         delta <= '0;
      end else begin
         prev  <= now;
         delta <= (clr ? '0 : delta) | (now ^ prev);
      end
   end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             reload,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = (divisor != '0) && (cnt <= DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (reload)     cnt <= '0;
      else if (tick)       cnt <= divisor;
      else if (cnt != '0)  cnt <= cnt - DIV_W'(1);
   end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
   import uart_regfile_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int RX_DEPTH    = 16,
   parameter int LVL_W       = $clog2(RX_DEPTH + 1),
   parameter int MODEM_W     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_RESET   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic                  rd,
   input  logic                  wr,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   output logic                  irq,
   output logic                  tx_push,
   output logic [DATA_W-1:0]     tx_data,
   input  logic                  tx_empty,
   output logic                  rx_pop,
   input  logic [DATA_W-1:0]     rx_data,
   input  logic [LVL_W-1:0]      rx_level,
   input  logic                  rx_line_err,
   input  logic [MODEM_W-1:0]    modem_in,
   output logic                  fifo_en,
   output logic                  rx_fifo_clr,
   output logic                  tx_fifo_clr,
   output logic [1:0]            word_len,
   output logic                  stop_two,
   output logic [2:0]            parity_mode,
   output logic                  brk,
   output logic [2*DATA_W-1:0]   divisor,
   output logic                  baud_tick
);

   localparam int DIV_W = 2 * DATA_W;
   localparam int IDX_W = $clog2(NSRC);
   localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(DIV_RESET);
   localparam logic [LVL_W-1:0] TRIG0 = LVL_W'(1);
   localparam logic [LVL_W-1:0] TRIG1 = LVL_W'(RX_DEPTH / 4);
   localparam logic [LVL_W-1:0] TRIG2 = LVL_W'(RX_DEPTH / 2);
   localparam logic [LVL_W-1:0] TRIG3 = LVL_W'(RX_DEPTH - 2);

   // elaboration-time parameter checks
   generate
      if (DATA_W != 8) begin : g_chk_data
         $error("uart_regfile: DATA_W must be 8");
      end
      if (MODEM_W != 4) begin : g_chk_modem
         $error("uart_regfile: MODEM_W must be 4");
      end
      if (ADDR_W < 3) begin : g_chk_addr
         $error("uart_regfile: ADDR_W must be at least 3");
      end
      if (RX_DEPTH < 4 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_chk_depth
         $error("uart_regfile: RX_DEPTH must be a power of two, at least 4");
      end
      if (LVL_W < $clog2(RX_DEPTH + 1)) begin : g_chk_lvl
         $error("uart_regfile: LVL_W too narrow for RX_DEPTH");
      end
   endgenerate

   // access decode
   logic rd_s, wr_s;
   logic a_data, a_ien, a_isr, a_lcr, a_msr, a_scr;
   assign rd_s   = cs & rd;
   assign wr_s   = cs & wr;
   assign a_data = (addr == ADDR_W'(OFS_DATA));
   assign a_ien  = (addr == ADDR_W'(OFS_IEN));
   assign a_isr  = (addr == ADDR_W'(OFS_ISR));
   assign a_lcr  = (addr == ADDR_W'(OFS_LCR));
   assign a_msr  = (addr == ADDR_W'(OFS_MSR));
   assign a_scr  = (addr == ADDR_W'(OFS_SCR));

   // state
   line_cfg_t          lcr_q;
   logic [IEN_W-1:0]   ien_q;
   logic [DATA_W-1:0]  scr_q, dll_q, dlm_q;
   logic               fen_q, rxclr_q, txclr_q;
   logic [1:0]         trig_q;
   logic               thre_pend, txe_q;

   logic               dlab;
   assign dlab = lcr_q.dlab;

   // FIFO strobes
   assign tx_push = wr_s & a_data & ~dlab;
   assign tx_data = wdata;
   assign rx_pop  = rd_s & a_data & ~dlab;

   // interrupt ranking
   logic [NSRC-1:0]   req;
   logic              any;
   logic [IDX_W-1:0]  sel;
   logic [LVL_W-1:0]  trig_lvl;
   logic [MODEM_W-1:0] modem_now, modem_delta;

   always_comb begin
      if (!fen_q) trig_lvl = TRIG0;
      else begin
         case (trig_q)
            2'd0:    trig_lvl = TRIG0;
            2'd1:    trig_lvl = TRIG1;
            2'd2:    trig_lvl = TRIG2;
            default: trig_lvl = TRIG3;
         endcase
      end
   end

   always_comb begin
      req           = '0;
      req[SRC_LINE] = rx_line_err & ien_q[IEN_LINE];
      req[SRC_RXD]  = (rx_level >= trig_lvl) & ien_q[IEN_RXD];
      req[SRC_TXE]  = thre_pend & ien_q[IEN_TXE];
      req[SRC_MDM]  = (|modem_delta) & ien_q[IEN_MDM];
   end

   uart_irq_prio #(.NREQ(NSRC), .IDX_W(IDX_W)) u_prio (
      .req (req),
      .any (any),
      .idx (sel)
   );

   assign irq = any;

   logic [DATA_W-1:0] isr_val;
   assign isr_val = {4'b0000, (any ? src_code(int'(sel)) : 3'b000), ~any};

   // transmit-empty latch
   logic thre_set, thre_clr;
   assign thre_set = (tx_empty & ~txe_q)
                   | (wr_s & a_ien & ~dlab & wdata[IEN_TXE] & ~ien_q[IEN_TXE] & tx_empty);
   assign thre_clr = (rd_s & a_isr & any & (sel == IDX_W'(SRC_TXE))) | tx_push;

   // modem status
   uart_modem_status #(.W(MODEM_W), .SYNC_STAGES(SYNC_STAGES)) u_modem (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (modem_in),
      .clr   (rd_s & a_msr),
      .now   (modem_now),
      .delta (modem_delta)
   );

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q     <= '0;
         ien_q     <= '0;
         scr_q     <= '0;
         dll_q     <= DIV_RST_V[DATA_W-1:0];
         dlm_q     <= DIV_RST_V[DIV_W-1:DATA_W];
         fen_q     <= 1'b0;
         trig_q    <= 2'd0;
         rxclr_q   <= 1'b0;
         txclr_q   <= 1'b0;
         thre_pend <= 1'b0;
         txe_q     <= 1'b1;
      end else begin
         rxclr_q   <= 1'b0;
         txclr_q   <= 1'b0;
         txe_q     <= tx_empty;
         thre_pend <= thre_set | (thre_pend & ~thre_clr);
         if (wr_s) begin
            if (a_data && dlab)  dll_q <= wdata;
            if (a_ien && dlab)   dlm_q <= wdata;
            if (a_ien && !dlab)  ien_q <= wdata[IEN_W-1:0];
            if (a_lcr)           lcr_q <= line_cfg_t'(wdata);
            if (a_scr)           scr_q <= wdata;
            if (a_isr) begin
               fen_q   <= wdata[0];
               rxclr_q <= wdata[1];
               txclr_q <= wdata[2];
               trig_q  <= wdata[7:6];
            end
         end
      end
   end

   // read mux
   always_comb begin
      rdata = '0;
      if (a_data)     rdata = dlab ? dll_q : rx_data;
      else if (a_ien) rdata = dlab ? dlm_q : DATA_W'(ien_q);
      else if (a_isr) rdata = isr_val;
      else if (a_lcr) rdata = DATA_W'(lcr_q);
      else if (a_msr) rdata = {modem_now, modem_delta};
      else if (a_scr) rdata = scr_q;
   end

   // configuration outputs
   assign fifo_en     = fen_q;
   assign rx_fifo_clr = rxclr_q;
   assign tx_fifo_clr = txclr_q;
   assign word_len    = lcr_q.wlen;
   assign stop_two    = lcr_q.stop2;
   assign parity_mode = lcr_q.par;
   assign brk         = lcr_q.brk;
   assign divisor     = {dlm_q, dll_q};

   uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .reload  (wr_s & dlab & (a_data | a_ien)),
      .tick    (baud_tick)
   );

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
   parameter int ADDR_W  = 3,
   parameter int DIV_W   = 16,
   parameter int MODEM_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs,
   input logic               wr,
   input logic               tx_push,
   input logic               rx_pop,
   input logic               rx_fifo_clr,
   input logic               tx_fifo_clr,
   input logic               brk,
   input logic [DIV_W-1:0]   divisor,
   input logic               baud_tick,
   input logic [MODEM_W-1:0] modem_now,
   input logic [MODEM_W-1:0] modem_delta
);

   // R5
   rxclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_clr |=> !rx_fifo_clr);

   // R5
   txclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_clr |=> !tx_fifo_clr);

   // R2
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_push && rx_pop));

   // R10
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && divisor > DIV_W'(1) && !(cs && wr)) |=> !baud_tick);

   // R9
   delta_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(modem_now) |=>
         ((modem_delta & $past(modem_now ^ $past(modem_now))) == $past(modem_now ^ $past(modem_now))));

   // R4
   brk_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(brk) |-> $past(cs && wr));

endmodule

bind uart_regfile uart_regfile_chk #(
   .ADDR_W  (ADDR_W),
   .DIV_W   (2 * DATA_W),
   .MODEM_W (MODEM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs          (cs),
   .wr          (wr),
   .tx_push     (tx_push),
   .rx_pop      (rx_pop),
   .rx_fifo_clr (rx_fifo_clr),
   .tx_fifo_clr (tx_fifo_clr),
   .brk         (brk),
   .divisor     (divisor),
   .baud_tick   (baud_tick),
   .modem_now   (modem_now),
   .modem_delta (modem_delta)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq;
   logic        tx_push;
   logic [7:0]  tx_data;
   logic        tx_empty = 1'b1;
   logic        rx_pop;
   logic [7:0]  rx_data = 8'h3C;
   logic [4:0]  rx_level = '0;
   logic        rx_line_err = 1'b0;
   logic [3:0]  modem_in = '0;
   logic        fifo_en, rx_fifo_clr, tx_fifo_clr, stop_two, brk, baud_tick;
   logic [1:0]  word_len;
   logic [2:0]  parity_mode;
   logic [15:0] divisor;

   int n_chk = 0;
   int n_fail = 0;
   logic       s_push, s_pop;
   logic [7:0] s_txd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .tx_push(tx_push),
      .tx_data(tx_data), .tx_empty(tx_empty), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_level(rx_level), .rx_line_err(rx_line_err),
      .modem_in(modem_in), .fifo_en(fifo_en), .rx_fifo_clr(rx_fifo_clr),
      .tx_fifo_clr(tx_fifo_clr), .word_len(word_len), .stop_two(stop_two),
      .parity_mode(parity_mode), .brk(brk), .divisor(divisor),
      .baud_tick(baud_tick)
   );

   // {write, addr, data, expected}
   localparam int NVEC = 12;
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b1, 3'd3, 8'h1B, 8'h00},
      {1'b0, 3'd3, 8'h00, 8'h1B},
      {1'b1, 3'd5, 8'hA5, 8'h00},
      {1'b0, 3'd5, 8'h00, 8'hA5},
      {1'b1, 3'd5, 8'h5A, 8'h00},
      {1'b0, 3'd5, 8'h00, 8'h5A},
      {1'b0, 3'd3, 8'h00, 8'h1B},
      {1'b1, 3'd1, 8'hF0, 8'h00},
      {1'b0, 3'd1, 8'h00, 8'h00},
      {1'b0, 3'd6, 8'h00, 8'h00},
      {1'b0, 3'd7, 8'h00, 8'h00},
      {1'b0, 3'd2, 8'h00, 8'h01}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      #1;
      s_push = tx_push; s_txd = tx_data; s_pop = rx_pop;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      cs = 1'b1; rd = 1'b1; addr = a;
      #1;
      d = rdata; s_push = tx_push; s_pop = rx_pop;
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] d;
      bus_rd(a, d);
      chk(tag, {24'd0, d}, {24'd0, exp});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      int ticks;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 divisor", {16'd0, divisor}, 32'd1);
      chk("R1 fifo_en/clr", {29'd0, fifo_en, rx_fifo_clr, tx_fifo_clr}, 32'd0);
      chk("R1 line outs", {25'd0, word_len, stop_two, parity_mode, brk}, 32'd0);
      rd_chk("R1 status", 3'd2, 8'h01);
      rd_chk("R1 line byte", 3'd3, 8'h00);

      // R4 table walk
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][19]) bus_wr(VEC[i][18:16], VEC[i][15:8]);
         else rd_chk("R4 table read", VEC[i][18:16], VEC[i][7:0]);
      end
      chk("R4 line outs", {25'd0, word_len, stop_two, parity_mode, brk}, {25'd0, 2'd3, 1'b0, 3'b011, 1'b0});
      bus_wr(3'd3, 8'h40);
      chk("R4 break out", {31'd0, brk}, 32'd1);
      bus_wr(3'd3, 8'h03);

      // R2 data port
      bus_wr(3'd0, 8'h77);
      chk("R2 push", {23'd0, s_push, s_txd}, {23'd0, 1'b1, 8'h77});
      bus_rd(3'd0, d);
      chk("R2 pop", {23'd0, s_pop, d}, {23'd0, 1'b1, 8'h3C});
      bus_rd(3'd5, d);
      chk("R2 no pop on scratch", {30'd0, s_pop, s_push}, 32'd0);

      // R3 divisor access
      bus_wr(3'd3, 8'h83);
      bus_wr(3'd0, 8'h34);
      chk("R3 no push", {31'd0, s_push}, 32'd0);
      bus_wr(3'd1, 8'h12);
      chk("R3 divisor out", {16'd0, divisor}, 32'h1234);
      bus_rd(3'd0, d);
      chk("R3 low byte, no pop", {23'd0, s_pop, d}, {23'd0, 1'b0, 8'h34});
      rd_chk("R3 high byte", 3'd1, 8'h12);
      bus_wr(3'd3, 8'h03);
      rd_chk("R3 enable reg again", 3'd1, 8'h00);

      // R5 FIFO settings
      bus_wr(3'd2, 8'h87);
      chk("R5 clr pulses", {29'd0, fifo_en, rx_fifo_clr, tx_fifo_clr}, 32'd7);
      @(negedge clk);
      chk("R5 clr self-return", {29'd0, fifo_en, rx_fifo_clr, tx_fifo_clr}, 32'd4);
      rd_chk("R5 offset 2 reads status", 3'd2, 8'h01);

      // R6 trigger levels
      bus_wr(3'd1, 8'h01);
      bus_wr(3'd2, 8'hC0);
      rx_level = 5'd1;
      #1 rd_chk("R6 fifo off trigger 1", 3'd2, 8'h04);
      bus_wr(3'd2, 8'hC1);
      rd_chk("R6 level 1 under 14", 3'd2, 8'h01);
      rx_level = 5'd13;
      #1 rd_chk("R6 level 13 under 14", 3'd2, 8'h01);
      @(negedge clk);
      rx_level = 5'd14;
      #1 rd_chk("R6 level 14", 3'd2, 8'h04);
      @(negedge clk);
      bus_wr(3'd2, 8'h41);
      rx_level = 5'd3;
      #1 rd_chk("R6 level 3 under 4", 3'd2, 8'h01);
      @(negedge clk);
      rx_level = 5'd4;
      #1 rd_chk("R6 level 4", 3'd2, 8'h04);
      rx_level = 5'd0;

      // R11 enable gating
      bus_wr(3'd1, 8'h00);
      rx_line_err = 1'b1; rx_level = 5'd14;
      #1 chk("R11 disabled irq", {31'd0, irq}, 32'd0);
      rd_chk("R11 disabled status", 3'd2, 8'h01);
      bus_wr(3'd1, 8'h04);
      chk("R11 enabled irq", {31'd0, irq}, 32'd1);
      rd_chk("R11 line status", 3'd2, 8'h06);
      rx_line_err = 1'b0; rx_level = 5'd0;
      bus_wr(3'd1, 8'h00);

      // R8 transmit empty
      bus_wr(3'd1, 8'h02);
      chk("R8 enable while empty", {31'd0, irq}, 32'd1);
      rd_chk("R8 status shows txe", 3'd2, 8'h02);
      chk("R8 cleared by status read", {31'd0, irq}, 32'd0);
      rd_chk("R8 status after clear", 3'd2, 8'h01);
      tx_empty = 1'b0;
      repeat (2) @(negedge clk);
      tx_empty = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 rising empty", {31'd0, irq}, 32'd1);
      bus_wr(3'd0, 8'h11);
      chk("R8 cleared by push", {31'd0, irq}, 32'd0);
      bus_wr(3'd1, 8'h00);

      // R9 modem status
      modem_in = 4'b0101;
      repeat (4) @(negedge clk);
      rd_chk("R9 change flags", 3'd4, 8'h55);
      rd_chk("R9 flags cleared", 3'd4, 8'h50);
      modem_in = 4'b0000;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      bus_rd(3'd4, d);
      repeat (2) @(negedge clk);
      rd_chk("R9 set wins over read clear", 3'd4, 8'h05);
      modem_in = 4'b0101;
      repeat (4) @(negedge clk);
      rd_chk("R9 second change", 3'd4, 8'h55);
      modem_in = 4'b0000;
      repeat (4) @(negedge clk);

      // R7 priority chain
      bus_wr(3'd1, 8'h0F);
      rx_line_err = 1'b1; rx_level = 5'd4;
      #1 rd_chk("R7 line error first", 3'd2, 8'h06);
      rx_line_err = 1'b0;
      #1 rd_chk("R7 rx data second", 3'd2, 8'h04);
      rx_level = 5'd0;
      #1 rd_chk("R7 txe third", 3'd2, 8'h02);
      rd_chk("R7 modem last", 3'd2, 8'h00);
      chk("R7 irq on modem", {31'd0, irq}, 32'd1);
      rd_chk("R7 msr read", 3'd4, 8'h05);
      rd_chk("R7 none", 3'd2, 8'h01);
      chk("R7 irq idle", {31'd0, irq}, 32'd0);
      bus_wr(3'd1, 8'h00);

      // R10 baud tick
      bus_wr(3'd3, 8'h83);
      bus_wr(3'd0, 8'h03);
      bus_wr(3'd1, 8'h00);
      bus_wr(3'd3, 8'h03);
      repeat (5) @(negedge clk);
      ticks = 0;
      for (int c = 0; c < 30; c++) begin
         if (baud_tick) ticks++;
         @(negedge clk);
      end
      chk("R10 divisor 3 rate", ticks, 10);
      bus_wr(3'd3, 8'h83);
      bus_wr(3'd0, 8'h00);
      bus_wr(3'd3, 8'h03);
      ticks = 0;
      for (int c = 0; c < 20; c++) begin
         if (baud_tick) ticks++;
         @(negedge clk);
      end
      chk("R10 divisor 0 silent", ticks, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule